// File: doc/BRIEF.md
# Integer ALU with Condition Codes

A 32-bit integer arithmetic and logic unit that combines two operands under a 4-bit opcode and keeps its own condition-code register. It offers four arithmetic operations: add, add with stored carry, subtract, and subtract with stored borrow. It also offers six bitwise operations: AND, OR, XOR, AND with inverted second operand, OR with inverted second operand, and XNOR. The result is combinational. A separate `setCc` input chooses whether the operation also rewrites the negative, zero, overflow and carry flags.

The flags sit in a register inside the block. That register is written on a rising clock edge only when `opValid` and `setCc` are both high. The two extended arithmetic operations take their extra input from the stored carry. A program can therefore chain multi-word additions and subtractions through successive operations.

Top module: `int_alu_cc`

## Requirements
- R1: Opcode 0 gives srcA+srcB, 1 gives srcA+srcB+C, 2 gives srcA-srcB and 3 gives srcA-srcB-C, all modulo 2^32, where C is the stored carry flag.
- R2: Opcode 4 gives A&B, 5 gives A|B, 6 gives A^B, 7 gives A&~B, 8 gives A|~B and 9 gives ~(A^B).
- R3: Opcodes 1 and 3 use the carry flag stored before the operation's own clock edge as carry-in or borrow-in. Opcodes 0 and 2 ignore it.
- R4: On a flag write, Z is set exactly when the 32-bit result is zero, and N equals result bit 31.
- R5: On an arithmetic flag write, C is the carry out of the 33-bit unsigned sum for opcodes 0 and 1. For opcodes 2 and 3, C is the borrow: it is set exactly when srcA is unsigned-less-than srcB plus borrow-in.
- R6: On an arithmetic flag write, V is bit 31 of (~(A^B) & (A^result)) for addition and bit 31 of ((A^B) & (A^result)) for subtraction.
- R7: A flag-setting bitwise operation clears C and V.
- R8: The flags keep their value across any edge where `setCc` is low or `opValid` is low.
- R9: The flags output is {N,Z,V,C} in bits 3 down to 0. It is all zero during and after reset, and it changes only on the rising clock edge that samples the write.
- R10: Opcodes 10 to 15 are reserved. They give a zero result and never write the flags, even with `setCc` high.
- R11: The result depends only on the operands, the opcode and the stored carry; `opValid` and `setCc` do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opValid | input | 1 | Qualifies the current operation for a flag write |
| setCc | input | 1 | Selects the flag-updating form of the operation |
| opCode | input | 4 | Operation select (see R1, R2, R10) |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| result | output | 32 | Combinational operation result |
| flags | output | 4 | Stored condition codes {N,Z,V,C} |

## Verification
The clocked properties assume that `opValid`, `setCc` and `opCode` hold known values in every cycle after reset is released. They also assume the operands are known whenever a flag write is requested. The stimulus drives every input to a defined value from time zero and changes inputs only on the falling edge. Unused cycles therefore present a deasserted `opValid` together with settled operands.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADDC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUBB = 4'd3;
  localparam logic [OP_W-1:0] OP_AND  = 4'd4;
  localparam logic [OP_W-1:0] OP_OR   = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd6;
  localparam logic [OP_W-1:0] OP_ANDN = 4'd7;
  localparam logic [OP_W-1:0] OP_ORN  = 4'd8;
  localparam logic [OP_W-1:0] OP_XNOR = 4'd9;

  typedef enum logic [1:0] {
    LFN_AND = 2'd0,
    LFN_OR  = 2'd1,
    LFN_XOR = 2'd2
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     arith;    // adder path selected
    logic     sub;      // subtract instead of add
    logic     useCin;   // fold stored carry into the adder
    logic     invB;     // invert second operand on the bitwise path
    logicFn_e fn;       // bitwise function
    logic     zeroRes;  // reserved opcode: force result to zero
    logic     wrFlags;  // write the condition-code register this cycle
  } aluCtrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } aluFlags_t;

endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            setCc,
  input  logic            opValid,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.fn      = LFN_AND;
    case (opCode)
      OP_ADD:  ctrl.arith = 1'b1;
      OP_ADDC: begin ctrl.arith = 1'b1; ctrl.useCin = 1'b1; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; end
      OP_SUBB: begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.useCin = 1'b1; end
      OP_AND:  ctrl.fn = LFN_AND;
      OP_OR:   ctrl.fn = LFN_OR;
      OP_XOR:  ctrl.fn = LFN_XOR;
      OP_ANDN: begin ctrl.fn = LFN_AND; ctrl.invB = 1'b1; end
      OP_ORN:  begin ctrl.fn = LFN_OR;  ctrl.invB = 1'b1; end
      OP_XNOR: begin ctrl.fn = LFN_XOR; ctrl.invB = 1'b1; end
      default: ctrl.zeroRes = 1'b1;
    endcase
    ctrl.wrFlags = opValid & setCc & ~ctrl.zeroRes;
  end

  // R3
  always_comb begin
    cin_only_arith_chk: assert (!ctrl.useCin || ctrl.arith);
  end

endmodule

// File: rtl/alu_cc_dpath.sv
module alu_cc_dpath
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flagsQ
);

  localparam int MSB  = DATA_W - 1;
  localparam int WIDE = DATA_W + 1;

  logic              carryIn;
  logic [WIDE-1:0]   wideSum;
  logic [DATA_W-1:0] bMod;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] ovfVec;
  aluFlags_t         flagsNxt;

  // adder / subtractor with one extra bit for carry or borrow
  always_comb begin
    carryIn = ctrl.useCin & flagsQ.c;
    if (ctrl.sub)
      wideSum = {1'b0, srcA} - {1'b0, srcB} - {{DATA_W{1'b0}}, carryIn};
    else
      wideSum = {1'b0, srcA} + {1'b0, srcB} + {{DATA_W{1'b0}}, carryIn};
  end

  // bitwise unit
  always_comb begin
    bMod = ctrl.invB ? ~srcB : srcB;
    case (ctrl.fn)
      LFN_OR:  logicRes = srcA | bMod;
      LFN_XOR: logicRes = srcA ^ bMod;
      default: logicRes = srcA & bMod;
    endcase
  end

  always_comb begin
    if (ctrl.zeroRes)
      result = '0;
    else if (ctrl.arith)
      result = wideSum[DATA_W-1:0];
    else
      result = logicRes;
  end

  // next condition codes
  always_comb begin
    if (ctrl.sub)
      ovfVec = (srcA ^ srcB) & (srcA ^ result);
    else
      ovfVec = ~(srcA ^ srcB) & (srcA ^ result);
    flagsNxt.n = result[MSB];
    flagsNxt.z = (result == '0);
    flagsNxt.v = ctrl.arith & ovfVec[MSB];
    flagsNxt.c = ctrl.arith & wideSum[DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flagsQ <= '0;
    else if (ctrl.wrFlags)
      flagsQ <= flagsNxt;
  end

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.wrFlags |=> $stable(flagsQ));

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.wrFlags && !ctrl.arith) |=> (!flagsQ.c && !flagsQ.v));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.wrFlags |=> (flagsQ.z == ($past(result) == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.wrFlags |=> (flagsQ.n == $past(result[MSB])));

  // R5
  no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.wrFlags && ctrl.sub && !ctrl.useCin && (srcA >= srcB)) |=> !flagsQ.c);

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic              setCc,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);

  aluCtrl_t  ctrl;
  aluFlags_t flagsQ;

  alu_cc_ctrl u_ctrl (
    .opCode  (opCode),
    .setCc   (setCc),
    .opValid (opValid),
    .ctrl    (ctrl)
  );

  alu_cc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result),
    .flagsQ (flagsQ)
  );

  assign flags = flagsQ;

  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode > OP_XNOR) |=> $stable(flags));

endmodule

// File: tb/int_alu_cc_test.sv
module int_alu_cc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic        setCc = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] result;
  logic [3:0]  flags;

  int nChecks = 0;
  int nFail = 0;
  logic [3:0] mFlags = 4'b0000; // {N,Z,V,C} model

  always #4 clk = ~clk; // 125 MHz

  int_alu_cc uut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .setCc(setCc),
    .opCode(opCode), .srcA(srcA), .srcB(srcB), .result(result), .flags(flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation: drive at falling edge, check result, then flags after the edge
  task automatic runOp(input logic [3:0] op, input logic cc, input logic vld,
                       input logic [31:0] a, input logic [31:0] b,
                       input string resTag, input string flgTag);
    logic [63:0] wide;
    longint      sv;
    logic [31:0] expRes;
    logic        cin, c, v;
    logic [3:0]  expFlags;
    cin = (op == 4'd1 || op == 4'd3) ? mFlags[0] : 1'b0;
    c = 1'b0; v = 1'b0; expRes = '0;
    case (op)
      4'd0, 4'd1: begin
        wide   = {32'b0, a} + {32'b0, b} + {63'b0, cin};
        expRes = wide[31:0];
        c      = (wide > 64'hFFFF_FFFF);
        sv     = longint'($signed(a)) + longint'($signed(b)) + longint'(cin);
        v      = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        expRes = a - b - {31'b0, cin};
        c      = ({32'b0, a} < ({32'b0, b} + {63'b0, cin}));
        sv     = longint'($signed(a)) - longint'($signed(b)) - longint'(cin);
        v      = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      4'd4: expRes = a & b;
      4'd5: expRes = a | b;
      4'd6: expRes = a ^ b;
      4'd7: expRes = a & ~b;
      4'd8: expRes = a | ~b;
      4'd9: expRes = ~(a ^ b);
      default: expRes = '0;
    endcase
    expFlags = (vld && cc && op < 4'd10) ? {expRes[31], (expRes == 32'd0), v, c} : mFlags;
    opCode = op; setCc = cc; opValid = vld; srcA = a; srcB = b;
    #1;
    check(resTag, result, expRes);
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    #1;
    check(flgTag, {28'b0, flags}, {28'b0, expFlags});
    mFlags = expFlags;
  endtask

  task automatic testReset;
    check("R9 flags zero in reset", {28'b0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 flags zero after reset", {28'b0, flags}, 32'd0);
  endtask

  task automatic testAddSub;
    runOp(4'd0, 1'b1, 1'b1, 32'd5, 32'd7, "R1 add", "R4 add flags");
    runOp(4'd0, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'd1, "R1 add ovf", "R6 add overflow");
    runOp(4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1, "R1 add wrap", "R5 add carry zero");
    runOp(4'd2, 1'b1, 1'b1, 32'd0, 32'd1, "R1 sub", "R5 sub borrow");
    runOp(4'd2, 1'b1, 1'b1, 32'h8000_0000, 32'd1, "R1 sub ovf", "R6 sub overflow");
    runOp(4'd2, 1'b1, 1'b1, 32'd9, 32'd9, "R1 sub equal", "R4 sub zero");
  endtask

  task automatic testCarryChain;
    runOp(4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd2, "R1 add low word", "R5 carry out");
    runOp(4'd1, 1'b1, 1'b1, 32'd1, 32'd1, "R3 addc uses carry", "R3 addc flags");
    runOp(4'd0, 1'b0, 1'b1, 32'd1, 32'd1, "R3 add ignores carry", "R8 no cc");
    runOp(4'd2, 1'b1, 1'b1, 32'd1, 32'd2, "R1 sub low word", "R5 borrow set");
    runOp(4'd3, 1'b1, 1'b1, 32'd10, 32'd3, "R3 subb uses borrow", "R3 subb flags");
    runOp(4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1, "R1 set carry", "R5 carry");
    runOp(4'd1, 1'b1, 1'b1, 32'd5, 32'hFFFF_FFFF, "R3 addc full wrap", "R5 addc carry with cin");
    runOp(4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd1, "R1 set carry again", "R5 carry again");
    runOp(4'd3, 1'b1, 1'b1, 32'd0, 32'hFFFF_FFFF, "R3 subb full wrap", "R5 subb borrow with cin");
  endtask

  task automatic testLogic;
    runOp(4'd0, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, "R1 prime", "R6 prime C and V");
    runOp(4'd4, 1'b1, 1'b1, 32'hF0F0_1234, 32'h0FF0_FF00, "R2 and", "R7 and clears CV");
    runOp(4'd5, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_0001, "R2 or", "R4 or negative");
    runOp(4'd6, 1'b1, 1'b1, 32'hAAAA_5555, 32'hAAAA_5555, "R2 xor", "R4 xor zero");
    runOp(4'd7, 1'b0, 1'b1, 32'hFFFF_00FF, 32'h0F0F_0F0F, "R2 andn", "R8 andn no cc");
    runOp(4'd8, 1'b0, 1'b1, 32'h0000_0000, 32'h1234_5678, "R2 orn", "R8 orn no cc");
    runOp(4'd9, 1'b1, 1'b1, 32'h1234_5678, 32'h1234_5678, "R2 xnor", "R7 xnor flags");
    runOp(4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, "R1 prime2", "R6 prime2");
    runOp(4'd7, 1'b1, 1'b1, 32'h1234_5678, 32'h1234_5678, "R2 andn cc", "R7 andn clears CV");
  endtask

  task automatic testHoldAndReserved;
    runOp(4'd2, 1'b1, 1'b1, 32'd0, 32'd3, "R1 prime3", "R5 prime3");
    runOp(4'd6, 1'b1, 1'b0, 32'd0, 32'd0, "R11 result without valid", "R8 valid low holds");
    runOp(4'd0, 1'b0, 1'b0, 32'd4, 32'd4, "R11 result idle", "R8 idle holds");
    runOp(4'd12, 1'b1, 1'b1, 32'h1234_5678, 32'd1, "R10 reserved result", "R10 reserved holds");
    runOp(4'd15, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 reserved top", "R10 reserved top holds");
  endtask

  initial begin
    #(8 * 20000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testAddSub();
    testCarryChain();
    testLogic();
    testHoldAndReserved();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule